// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a free-running timer value and fires an action whenever that value becomes equal to a stored 16-bit compare word. A 4-bit mode code chooses the action: flip the output pin, force it high, force it low, emit a one-cycle event pulse for neighbouring logic, or raise only the interrupt flag and leave the pin alone. In every active mode a match also latches an interrupt flag, which software clears through a dedicated input.

Software loads the compare word and the mode code through a single write port. The drive-enable output tells the pad whether this unit owns the pin. It does so in the toggle, set, clear and event modes, and releases the pin in the interrupt-only and inactive modes. The timer itself and the routing of the event pulse belong to other blocks.

Top module: `ocmp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears the compare word to 0 and the mode to 0000, and drives `pin_out`, `pin_oe`, `evt_trig` and `irq_flag` low after that edge.
- R2: With `wr_en` high at a clock edge, `wr_sel` = 0 loads `wr_data` into the compare word and `wr_sel` = 1 loads `wr_data[3:0]` into the mode code. The new value governs matching from the next cycle on.
- R3: A match acts only on the first cycle in which `timer_val` equals the compare word, including a cycle in which equality appears because the compare word was rewritten. A timer that stays on the matching value does not act again. The results appear on the outputs after the clock edge of that first cycle.
- R4: Mode 0010 inverts `pin_out` on each match.
- R5: Mode 1000 drives `pin_out` high on a match, and mode 1001 drives it low on a match.
- R6: Mode 1011 raises `evt_trig` for exactly one cycle on a match and leaves `pin_out` unchanged.
- R7: Mode 1010 sets only the interrupt flag on a match. `pin_out` keeps its level and `pin_oe` stays low.
- R8: In every active mode (0010, 1000, 1001, 1010, 1011), a match sets `irq_flag`. The flag stays high until a cycle with `irq_clr` high and no match. A match wins over a clear in the same cycle.
- R9: `pin_oe` is high exactly while the mode register holds 0010, 1000, 1001 or 1011. It changes only on the edge after a mode write.
- R10: Mode 0000 and every unlisted code are inactive. A match does nothing, and `pin_out` is driven low on the edge after the mode register first holds an inactive code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timer_val | input | 16 | Current timer count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 compare word, 1 mode code |
| wr_data | input | 16 | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin drive enable |
| evt_trig | output | 1 | One-cycle special event pulse |
| irq_flag | output | 1 | Sticky match interrupt flag |

## Verification
The assertions assume that `rst` is high from time zero for at least one clock edge. They also assume that `timer_val`, `wr_en` and `irq_clr` are settled at every rising edge, since the equality test and the flag logic sample them there. The stimulus meets both assumptions by holding reset for two edges at start-up and by changing every input only on the falling clock edge. It never clears the interrupt flag through a side path, and it never writes the mode during a cycle whose result it checks against a stale mode, because the one-cycle write latency of the mode register is built into every expected value.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int MODE_W = 4;

    typedef logic [MODE_W-1:0] mode_code_t;

    localparam mode_code_t MC_OFF      = 4'b0000;
    localparam mode_code_t MC_TOGGLE   = 4'b0010;
    localparam mode_code_t MC_SET      = 4'b1000;
    localparam mode_code_t MC_CLEAR    = 4'b1001;
    localparam mode_code_t MC_IRQ_ONLY = 4'b1010;
    localparam mode_code_t MC_EVENT    = 4'b1011;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TOGGLE,
        ACT_SET,
        ACT_CLEAR,
        ACT_IRQ,
        ACT_EVENT
    } act_e;

    typedef struct packed {
        act_e act;
        logic drive;
        logic active;
    } ctl_t;

    function automatic ctl_t decode_mode(mode_code_t code);
        ctl_t c;
        c = '{act: ACT_NONE, drive: 1'b0, active: 1'b0};
        case (code)
            MC_TOGGLE:   c = '{act: ACT_TOGGLE, drive: 1'b1, active: 1'b1};
            MC_SET:      c = '{act: ACT_SET,    drive: 1'b1, active: 1'b1};
            MC_CLEAR:    c = '{act: ACT_CLEAR,  drive: 1'b1, active: 1'b1};
            MC_EVENT:    c = '{act: ACT_EVENT,  drive: 1'b1, active: 1'b1};
            MC_IRQ_ONLY: c = '{act: ACT_IRQ,    drive: 1'b0, active: 1'b1};
            default:     c = '{act: ACT_NONE,   drive: 1'b0, active: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cmp_val,
    output mode_code_t   mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
            mode    <= MC_OFF;
        end else if (wr_en) begin
            if (wr_sel) mode    <= wr_data[MODE_W-1:0];
            else        cmp_val <= wr_data;
        end
    end

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic [W-1:0] timer_val,
    input  logic [W-1:0] cmp_val,
    output logic         fire
);

    logic eq_now;
    logic eq_prev;

    assign eq_now = active && (timer_val == cmp_val);
    assign fire   = eq_now && !eq_prev;

    always_ff @(posedge clk) begin
        if (rst) eq_prev <= 1'b0;
        else     eq_prev <= eq_now;
    end

    // R3: an equality run fires on its first cycle only
    a_r3_no_refire: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/ocmp_action.sv
module ocmp_action
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic fire,
    input  logic irq_clr,
    output logic pin,
    output logic trig,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin  <= 1'b0;
            trig <= 1'b0;
            irq  <= 1'b0;
        end else begin
            trig <= fire && (ctl.act == ACT_EVENT);
            if (fire)         irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
            if (!ctl.active) begin
                pin <= 1'b0;
            end else if (fire) begin
                case (ctl.act)
                    ACT_TOGGLE: pin <= ~pin;
                    ACT_SET:    pin <= 1'b1;
                    ACT_CLEAR:  pin <= 1'b0;
                    default:    pin <= pin;
                endcase
            end
        end
    end

    a_r6_trig_single: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r7_pin_released: assert property (@(posedge clk) disable iff (rst)
        (ctl.act == ACT_IRQ) |=> $stable(pin));

    a_r10_inactive_low: assert property (@(posedge clk) disable iff (rst)
        !ctl.active |=> !pin);

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] timer_val,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         irq_clr,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         evt_trig,
    output logic         irq_flag
);

    logic [W-1:0] cmp_val;
    mode_code_t   mode;
    ctl_t         ctl;
    logic         fire;

    ocmp_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmp_val (cmp_val),
        .mode    (mode)
    );

    assign ctl    = decode_mode(mode);
    assign pin_oe = ctl.drive;

    ocmp_match #(.W(W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .active    (ctl.active),
        .timer_val (timer_val),
        .cmp_val   (cmp_val),
        .fire      (fire)
    );

    ocmp_action u_action (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .fire    (fire),
        .irq_clr (irq_clr),
        .pin     (pin_out),
        .trig    (evt_trig),
        .irq     (irq_flag)
    );

    a_r8_irq_on_match: assert property (@(posedge clk) disable iff (rst)
        fire |=> irq_flag);

    a_r9_oe_on_write_only: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pin_oe));

endmodule

// File: tb/ocmp_unit_test.sv
module ocmp_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] timer_val = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_clr = 1'b0;
    logic        pin_out, pin_oe, evt_trig, irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected outputs packed as {pin_out, pin_oe, evt_trig, irq_flag}
    typedef struct {
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ocmp_unit uut (
        .clk(clk), .rst(rst), .timer_val(timer_val), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .evt_trig(evt_trig),
        .irq_flag(irq_flag)
    );

    // driver: applies one cycle of inputs, queues the outputs expected after the next edge
    task automatic step(input logic [15:0] t, input logic we, input logic sel,
                        input logic [15:0] d, input logic clr,
                        input logic [3:0] expv, input string tag);
        exp_t e;
        @(negedge clk);
        timer_val = t;
        wr_en     = we;
        wr_sel    = sel;
        wr_data   = d;
        irq_clr   = clr;
        e.val = expv;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one queued item just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                logic [3:0] act;
                e   = sb.pop_front();
                act = {pin_out, pin_oe, evt_trig, irq_flag};
                checks++;
                if (act !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual %b expected %b", e.tag, act, e.val);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(16'h0000, 0, 0, 16'h0000, 0, 4'b0000, "R1 reset outputs low");
        step(16'h0000, 0, 0, 16'h0000, 0, 4'b0000, "R1 reset held");
        @(negedge clk) rst = 1'b0;

        step(16'h0000, 1, 0, 16'h0100, 0, 4'b0000, "R2 load compare word");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b0000, "R10 off mode ignores match");
        step(16'h0050, 1, 1, 16'h0002, 0, 4'b0100, "R9 toggle mode drives pin");
        step(16'h00FF, 0, 0, 16'h0000, 0, 4'b0100, "R3 no match before value");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b1101, "R4 toggle to high");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b1101, "R3 held timer no retrigger");
        step(16'h0101, 0, 0, 16'h0000, 1, 4'b1100, "R8 flag cleared");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b0101, "R4 toggle to low");
        step(16'h0102, 0, 0, 16'h0000, 1, 4'b0100, "R8 flag cleared");

        step(16'h0102, 1, 1, 16'h0008, 0, 4'b0100, "R2 set mode written");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b1101, "R5 set drives high");
        step(16'h0000, 0, 0, 16'h0000, 1, 4'b1100, "R8 flag cleared");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b1101, "R5 set repeats high");
        step(16'h0101, 0, 0, 16'h0000, 1, 4'b1100, "R8 flag cleared");
        step(16'h0100, 0, 0, 16'h0000, 1, 4'b1101, "R8 match beats clear");

        step(16'h0000, 1, 1, 16'h0009, 1, 4'b1100, "R2 clear mode written");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b0101, "R5 clear drives low");
        step(16'h0001, 0, 0, 16'h0000, 1, 4'b0100, "R8 flag cleared");

        step(16'h0001, 1, 1, 16'h000B, 0, 4'b0100, "R9 event mode drives pin");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b0111, "R6 event pulse");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b0101, "R6 pulse one cycle");
        step(16'h0002, 0, 0, 16'h0000, 1, 4'b0100, "R8 flag cleared");

        step(16'h0002, 1, 1, 16'h0002, 0, 4'b0100, "R4 back to toggle");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b1101, "R4 toggle to high");
        step(16'h0003, 0, 0, 16'h0000, 1, 4'b1100, "R8 flag cleared");
        step(16'h0004, 1, 1, 16'h000A, 0, 4'b1000, "R7 irq-only releases pin");
        step(16'h0100, 0, 0, 16'h0000, 0, 4'b1001, "R7 match sets flag only");
        step(16'h0004, 0, 0, 16'h0000, 1, 4'b1000, "R8 flag cleared");

        step(16'h0200, 1, 0, 16'h0200, 0, 4'b1000, "R2 compare rewrite");
        step(16'h0200, 0, 0, 16'h0000, 0, 4'b1001, "R3 rewrite creates match");
        step(16'h0200, 0, 0, 16'h0000, 1, 4'b1000, "R3 no refire on hold");

        step(16'h0200, 1, 1, 16'h0000, 0, 4'b1000, "R10 off written");
        step(16'h0200, 0, 0, 16'h0000, 0, 4'b0000, "R10 off drives pin low");
        step(16'h0000, 1, 1, 16'h0005, 0, 4'b0000, "R10 unlisted code written");
        step(16'h0200, 0, 0, 16'h0000, 0, 4'b0000, "R10 unlisted code inert");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule